// File: doc/BRIEF.md
# CPU Cycle IRQ Counter

This block is a 16-bit interrupt timer that advances once per CPU bus cycle. Each rising edge of `clk` is one CPU cycle. Software sets it up through a small group of write-only registers. Each register sits in its own 256-byte page, and only address bits 15..8 select it. A reload value is written one byte at a time. A control register arms the counter and loads it from the reload value. An acknowledge register clears the interrupt and can re-arm the counter.

Once armed, the counter counts upward from the reload value. When it rolls over from $FFFF to $0000, the counter reloads and raises a level interrupt request. The request stays high until software writes the acknowledge or control register. The timer only counts bus cycles; it has no mode that counts lines of video. A register write that lands on the same cycle as a rollover takes precedence over that rollover.

Top module: `cyc_irq_timer`

## Requirements
- R1: After synchronous reset, `irq` is 0 and the counter is disarmed (enable and re-arm bits cleared, count and reload value zero). With no register writes, `irq` stays 0.
- R2: A register is selected by `bus_addr[15:8]` only, and only when `bus_wr` is 1. The low address byte is ignored. Writes to any other page, and cycles with `bus_wr` low, change nothing.
- R3: The reload value takes its low byte from writes to page $D6 and its high byte from writes to page $D7.
- R4: A write to page $D9 sets the live enable from data bit 1 and the re-arm bit from data bit 0. If data bit 1 is 1, that write loads the counter from the reload value. If data bit 1 is 0, the counter holds its value and stops.
- R5: Any write to page $D9 clears a pending interrupt.
- R6: Any write to page $D8 clears a pending interrupt and copies the re-arm bit into the live enable.
- R7: While enabled, the counter rises by one every cycle. On the cycle it leaves $FFFF, it takes the reload value instead of $0000 and the interrupt becomes pending. `irq` is 1 from the following cycle.
- R8: `irq` is active high and level. Once set, it stays 1 until a write to page $D8 or page $D9.
- R9: If a write to page $D8 or page $D9 falls on the rollover cycle, the write wins. No interrupt becomes pending, and the written effect on the enable and the counter applies.
- R10: Writing the reload bytes does not disturb a count in progress. The new value takes effect at the next load or rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock; every rising edge is one bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 16 | CPU address; bits 15..8 select the register |
| bus_wdata | input | 8 | Write data |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The assertions assume that a write strobe lasts exactly one cycle and that address and data are stable over that cycle. They also assume the reset is held for at least one edge before counting starts. The stimulus drives every write as a single-cycle pulse set up half a cycle before the edge. Between writes it holds `bus_wr` low, and it steps the address through mapped and unmapped pages alike. Writes that land on the rollover cycle are placed by counting edges from a known load. This means the coincidence cases hit the exact cycle instead of relying on chance.

// File: rtl/cirq_pkg.sv
// Package: cirq_pkg
// Shared definitions for the CPU cycle IRQ counter.
// Assumes the control register layout below is fixed by software convention.
package cirq_pkg;

    // Bit positions inside the control register write data
    localparam int CTRL_REARM_BIT = 0;
    localparam int CTRL_LIVE_BIT  = 1;

    // Enable state kept between writes
    typedef struct packed {
        logic live;   // counter currently advances
        logic rearm;  // value copied to live on acknowledge
    } enable_state_t;

endpackage

// File: rtl/cirq_decode.sv
// Module: cirq_decode
// Turns a bus write into one-cycle register strobes. Only the top PAGE_W
// address bits take part; the low byte is don't-care. Assumes all the page
// constants differ from one another.
module cirq_decode #(
    parameter int                ADDR_W      = 16,
    parameter int                PAGE_W      = 8,
    parameter int                LATCH_BYTES = 2,
    parameter logic [PAGE_W-1:0] LATCH_PAGE  = 8'hD6,
    parameter logic [PAGE_W-1:0] ACK_PAGE    = 8'hD8,
    parameter logic [PAGE_W-1:0] CTRL_PAGE   = 8'hD9
) (
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    output logic [LATCH_BYTES-1:0] latch_we,
    output logic                   ack_we,
    output logic                   ctrl_we
);

    localparam int OFFS_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic              unused_offset;

    // Split the address into page and ignored offset
    assign page          = wr_addr[ADDR_W-1:OFFS_W];
    assign unused_offset = ^wr_addr[OFFS_W-1:0];

    // One strobe per reload byte, on consecutive pages
    for (genvar b = 0; b < LATCH_BYTES; b++) begin : g_latch_hit
        localparam logic [PAGE_W-1:0] BYTE_PAGE = PAGE_W'(LATCH_PAGE + b);
        assign latch_we[b] = wr_en && (page == BYTE_PAGE);
    end

    // Acknowledge and control strobes
    assign ack_we  = wr_en && (page == ACK_PAGE);
    assign ctrl_we = wr_en && (page == CTRL_PAGE);

endmodule

// File: rtl/cirq_counter.sv
// Module: cirq_counter
// Up-counter with a synchronous load and automatic reload on rollover.
// Assumes load and count_en are never both set (the controller guarantees it);
// if they were, load takes priority.
module cirq_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    // Rollover happens when an enabled count leaves the all-ones value
    assign wrap = count_en && !load && (cnt == CNT_MAX);

    // Load, reload on rollover, or step by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (count_en) begin
            if (cnt == CNT_MAX) begin
                cnt <= load_val;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: an explicit load takes the reload value
    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R4: a stopped counter keeps its value
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !count_en) |=> $stable(cnt));

    // R7: one step per enabled cycle below the top value
    assert_step_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !load && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

    // R7: rollover reloads instead of reaching zero
    assert_reload_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == $past(load_val));

endmodule

// File: rtl/cirq_ctrl.sv
// Module: cirq_ctrl
// Holds the reload value, the enable state and the pending interrupt flag.
// Assumes the strobes from the decoder are mutually exclusive and one cycle
// long. A control or acknowledge write always beats a rollover in the same cycle.
module cirq_ctrl
    import cirq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LATCH_BYTES = 2,
    localparam int CNT_W      = DATA_W * LATCH_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LATCH_BYTES-1:0] latch_we,
    input  logic                   ack_we,
    input  logic                   ctrl_we,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   wrap,
    output logic [CNT_W-1:0]       reload_val,
    output logic                   load,
    output logic                   count_en,
    output logic                   irq
);

    enable_state_t en_q;
    logic          pending_q;

    // Reload value, one independently written byte per page
    for (genvar b = 0; b < LATCH_BYTES; b++) begin : g_latch_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_val[b*DATA_W +: DATA_W] <= '0;
            end else if (latch_we[b]) begin
                reload_val[b*DATA_W +: DATA_W] <= wr_data;
            end
        end

        // R3: the addressed byte takes the written data
        assert_latch_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
            latch_we[b] |=> reload_val[b*DATA_W +: DATA_W] == $past(wr_data));
    end

    // Enable bits: set by control writes, re-armed by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ctrl_we) begin
            en_q.live  <= wr_data[CTRL_LIVE_BIT];
            en_q.rearm <= wr_data[CTRL_REARM_BIT];
        end else if (ack_we) begin
            en_q.live  <= en_q.rearm;
        end
    end

    // Pending flag: register writes clear it with priority over rollover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (ack_we || ctrl_we) begin
            pending_q <= 1'b0;
        end else if (wrap) begin
            pending_q <= 1'b1;
        end
    end

    // Counter steering: a control write either loads or freezes the count
    assign load     = ctrl_we && wr_data[CTRL_LIVE_BIT];
    assign count_en = en_q.live && !ctrl_we;
    assign irq      = pending_q;

    // R4: live enable follows control data bit 1
    assert_ctrl_sets_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> en_q.live == $past(wr_data[CTRL_LIVE_BIT]));

    // R5: control write leaves no interrupt pending
    assert_ctrl_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !irq);

    // R6: acknowledge clears the interrupt
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> !irq);

    // R6: acknowledge copies the re-arm bit into the live enable
    assert_ack_rearms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !ctrl_we) |=> en_q.live == $past(en_q.rearm));

    // R7: an undisturbed rollover raises the interrupt
    assert_wrap_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ack_we && !ctrl_we) |=> irq);

    // R8: the request holds until a clearing write
    assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_we && !ctrl_we) |=> irq);

    // R9: a clearing write in the rollover cycle wins
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (ack_we || ctrl_we)) |=> !irq);

endmodule

// File: rtl/cyc_irq_timer.sv
// Module: cyc_irq_timer
// Top level of the CPU cycle IRQ counter: page decoder, control state and
// up-counter. Assumes clk ticks once per CPU bus cycle and that each bus
// write is presented for exactly one cycle.
module cyc_irq_timer #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                PAGE_W      = 8,
    parameter int                LATCH_BYTES = 2,
    parameter logic [PAGE_W-1:0] LATCH_PAGE  = 8'hD6,
    parameter logic [PAGE_W-1:0] ACK_PAGE    = 8'hD8,
    parameter logic [PAGE_W-1:0] CTRL_PAGE   = 8'hD9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              irq
);

    localparam int CNT_W = DATA_W * LATCH_BYTES;

    logic [LATCH_BYTES-1:0] latch_we;
    logic                   ack_we;
    logic                   ctrl_we;
    logic [CNT_W-1:0]       reload_val;
    logic                   load;
    logic                   count_en;
    logic                   wrap;

    // Register strobes from the bus
    cirq_decode #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .LATCH_BYTES (LATCH_BYTES),
        .LATCH_PAGE  (LATCH_PAGE),
        .ACK_PAGE    (ACK_PAGE),
        .CTRL_PAGE   (CTRL_PAGE)
    ) u_decode (
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .latch_we (latch_we),
        .ack_we   (ack_we),
        .ctrl_we  (ctrl_we)
    );

    // Reload value, enables and interrupt flag
    cirq_ctrl #(
        .DATA_W      (DATA_W),
        .LATCH_BYTES (LATCH_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_we   (latch_we),
        .ack_we     (ack_we),
        .ctrl_we    (ctrl_we),
        .wr_data    (bus_wdata),
        .wrap       (wrap),
        .reload_val (reload_val),
        .load       (load),
        .count_en   (count_en),
        .irq        (irq)
    );

    // Cycle counter
    cirq_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .count_en (count_en),
        .load_val (reload_val),
        .wrap     (wrap)
    );

endmodule

// File: tb/test_cyc_irq_timer.sv
`timescale 1ns/1ps
module test_cyc_irq_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_cnt, m_latch;
    bit m_live, m_rearm, m_pend;

    always #2.5 clk = ~clk;

    cyc_irq_timer i_cyc_irq_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model updated on each edge from the same inputs
    always @(posedge clk) begin
        int  page;
        bit  w_ctrl, w_ack;
        int  old_latch;
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_live = 0; m_rearm = 0; m_pend = 0;
        end else begin
            page      = bus_addr[15:8];
            w_ctrl    = bus_wr && page == 'hD9;
            w_ack     = bus_wr && page == 'hD8;
            old_latch = m_latch;
            if (w_ctrl) begin
                m_pend  = 0;
                m_live  = bus_wdata[1];
                m_rearm = bus_wdata[0];
                if (bus_wdata[1]) m_cnt = old_latch;
            end else begin
                if (m_live) begin
                    if (m_cnt == 65535) begin
                        m_cnt = old_latch;
                        if (!w_ack) m_pend = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
                if (w_ack) begin
                    m_pend = 0;
                    m_live = m_rearm;
                end
            end
            if (bus_wr && page == 'hD6) m_latch = (m_latch & 'hFF00) | bus_wdata;
            if (bus_wr && page == 'hD7) m_latch = (m_latch & 'h00FF) | (int'(bus_wdata) << 8);
        end
    end

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) chk(irq, m_pend, "R7/R8 model");
    end

    // One-cycle write; called at a negedge, returns at the next negedge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk(irq, 1'b0, "R1 reset");
        idle(20);
        chk(irq, 1'b0, "R1 idle after reset");

        // Reload $FFF0 through two byte pages, low address byte is don't-care
        wr(16'hD637, 8'hF0);
        wr(16'hD7C5, 8'hFF);
        wr(16'hD900, 8'h02);
        idle(15); chk(irq, 1'b0, "R7 before wrap");
        idle(1);  chk(irq, 1'b1, "R3 R7 wrap after 16 cycles");
        for (int i = 0; i < 10; i++) begin
            idle(1); chk(irq, 1'b1, "R8 level hold");
        end

        // Acknowledge with re-arm bit 0 stops the counter
        wr(16'hD800, 8'h00); chk(irq, 1'b0, "R6 ack clears");
        idle(100); chk(irq, 1'b0, "R6 rearm 0 stops");

        // Re-arm bit 1 keeps counting after acknowledge
        wr(16'hD900, 8'h03);
        idle(15); chk(irq, 1'b0, "R4 load then count");
        idle(1);  chk(irq, 1'b1, "R4 wrap from loaded value");
        wr(16'hD800, 8'h00); chk(irq, 1'b0, "R6 ack clears");
        idle(14); chk(irq, 1'b0, "R6 rearm 1 before wrap");
        idle(1);  chk(irq, 1'b1, "R6 rearm 1 keeps counting");

        // Control write with enable 0 clears and stops
        wr(16'hD900, 8'h00); chk(irq, 1'b0, "R5 ctrl clears");
        idle(50); chk(irq, 1'b0, "R4 enable 0 stops");

        // Ignored writes: foreign pages and strobe low
        wr(16'h56D6, 8'h00);
        wr(16'hDA00, 8'h00);
        wr(16'hD500, 8'h00);
        bus_addr = 16'hD600; bus_wdata = 8'h00; idle(1); bus_addr = '0;
        wr(16'hD900, 8'h02);
        idle(15); chk(irq, 1'b0, "R2 before wrap");
        idle(1);  chk(irq, 1'b1, "R2 reload unchanged by ignored writes");

        // Reload byte written mid-count applies only at the next reload
        wr(16'hD900, 8'h03);
        wr(16'hD600, 8'h00);
        idle(14); chk(irq, 1'b0, "R10 before wrap");
        idle(1);  chk(irq, 1'b1, "R10 running count kept");
        wr(16'hD800, 8'h00);
        idle(254); chk(irq, 1'b0, "R10 new value before wrap");
        idle(1);   chk(irq, 1'b1, "R10 new value used at reload");

        // Acknowledge on the rollover cycle wins
        wr(16'hD600, 8'hF0);
        wr(16'hD900, 8'h03);
        idle(15);
        wr(16'hD800, 8'h00); chk(irq, 1'b0, "R9 ack on wrap wins");
        idle(15); chk(irq, 1'b0, "R9 counting continues");
        idle(1);  chk(irq, 1'b1, "R9 next wrap after ack");

        // Control write on the rollover cycle wins
        wr(16'hD800, 8'h00);
        idle(14);
        wr(16'hD900, 8'h02); chk(irq, 1'b0, "R9 ctrl on wrap wins");
        idle(15); chk(irq, 1'b0, "R9 reloaded by ctrl");
        idle(1);  chk(irq, 1'b1, "R9 wrap after ctrl load");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule